// File: doc/BRIEF.md
# Relative Seek Cylinder Tracker

This block tracks the head position (cylinder and selected surface) of each drive in a multi-drive disk subsystem and carries out relative seeks. A seek command names a drive and supplies a 16-bit disk address word. That word carries an unsigned cylinder offset, a direction flag and a head-select flag. The block moves the drive's tracked cylinder by the offset, clamps it to the drive's range and records the new head. It then keeps the drive busy for a time proportional to the distance actually moved.

Each drive has its own large-capacity flag, which doubles its cylinder range. Each drive also has its own countdown, so seeks on different drives overlap freely. When a drive's countdown runs out, the block raises a one-cycle completion pulse for that drive. A programmable seek-wait constant sets the number of clock cycles charged per cylinder. The controller reset cancels every seek that is in flight, while the tracked positions survive it. Only the power-on reset returns the positions to cylinder 0, head 0.

Top module: `seek_tracker`

## Requirements
- R1: In `disk_addr`, bits 15:7 hold the unsigned cylinder offset, bit 2 is the direction flag (1 = outward/add, 0 = inward/subtract) and bit 4 is the new head. All other bits are ignored.
- R2: An outward seek sets the cylinder to current + offset. If that reaches or passes the drive's cylinder count, the cylinder becomes count - 1.
- R3: An inward seek sets the cylinder to current - offset. If the offset is larger than the current cylinder, the cylinder becomes 0.
- R4: The cylinder count is 256 when the drive's `big_drive` bit is 0 and 512 when it is 1.
- R5: Each drive's 16-bit `pos_word` carries the cylinder in bits 15:7 and the head in bit 6, with bits 5:0 zero. It takes its new value in the cycle after an accepted seek.
- R6: After an accepted seek, `drive_busy` is high for exactly wait × |new - old| cycles, starting the cycle after the start. The drive's `seek_done` bit is then high for exactly one cycle, the first cycle in which busy is low.
- R7: A seek that moves zero cylinders keeps the drive busy for exactly one cycle before its done pulse.
- R8: While `rst_n` is low, all busy and done outputs are 0 and seek starts are ignored. Tracked positions keep their values. `por_n` low clears positions to 0 and sets the wait constant to 10.
- R9: A seek start aimed at a drive that is busy is ignored: that drive's position and timing are unchanged.
- R10: The wait constant is 10 after power-on and is replaced by `cfg_wait` on a cycle with `cfg_wr` high. A seek uses the value held before the edge at which it starts.
- R11: Drives run independently: a seek on one drive does not alter the position, busy or done of any other drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears positions and the wait constant |
| rst_n | input | 1 | Controller reset, active low, cancels seeks |
| cfg_wr | input | 1 | Load the seek-wait constant |
| cfg_wait | input | 24 | New seek-wait constant in cycles per cylinder |
| seek_start | input | 1 | Start a seek on the selected drive |
| drive_sel | input | 2 | Drive index for the seek |
| disk_addr | input | 16 | Offset, direction and head word |
| big_drive | input | 4 | Per-drive large-capacity flag |
| drive_busy | output | 4 | Per-drive seek in progress |
| seek_done | output | 4 | Per-drive one-cycle completion pulse |
| pos_word | output | 64 | Per-drive position word, drive d at bits 16d+15:16d |

## Verification
The bench builds the block with its defaults: four drives, a 24-bit wait constant reset to 10, and cylinder counts of 256 and 512. With these values a full-range seek on a large drive at a wait of 2 lasts 1022 cycles, so both clamps and the longest distance can be checked within a short run. Lowering the wait constant to 1–3 cycles per cylinder keeps the zero-distance case, back-to-back starts on a busy drive and overlapping seeks on two drives short. Every position, busy and done output is compared each cycle against a behavioural model.

// File: rtl/seek_pkg.sv
package seek_pkg;
  // Field positions in the disk address word (decoded by the controller)
  localparam int ADDR_W       = 16;
  localparam int OFS_LSB      = 7;
  localparam int CYL_W        = ADDR_W - OFS_LSB;
  localparam int DIR_BIT      = 2;
  localparam int HEAD_BIT     = 4;
  // Position word layout
  localparam int POS_HEAD_BIT = 6;

  typedef struct packed {
    logic [CYL_W-1:0] cyl;
    logic             head;
  } drive_pos_t;
endpackage

// File: rtl/seek_calc.sv
module seek_calc
  import seek_pkg::*;
#(
  parameter int WAIT_W   = 24,
  parameter int STD_CYLS = 256,
  parameter int BIG_CYLS = 512,
  parameter int CNT_W    = WAIT_W + CYL_W
) (
  input  drive_pos_t              cur_pos,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    big,
  input  logic [WAIT_W-1:0]       wait_val,
  output drive_pos_t              nxt_pos,
  output logic [CNT_W-1:0]        load_cnt
);
  localparam logic [CYL_W:0] STD_LIM = (CYL_W+1)'(STD_CYLS);
  localparam logic [CYL_W:0] BIG_LIM = (CYL_W+1)'(BIG_CYLS);

  // Move relative to the current cylinder, clamped to [0, lim-1]
  function automatic logic [CYL_W-1:0] step_cyl(
    input logic [CYL_W-1:0] cur,
    input logic [CYL_W-1:0] ofs,
    input logic             outward,
    input logic [CYL_W:0]   lim
  );
    logic [CYL_W+1:0] sum;
    sum = {2'b00, cur} + {2'b00, ofs};
    if (outward)
      step_cyl = (sum >= {1'b0, lim}) ? CYL_W'(lim - 1'b1) : sum[CYL_W-1:0];
    else
      step_cyl = (ofs > cur) ? '0 : cur - ofs;
  endfunction

  function automatic logic [CYL_W-1:0] cyl_dist(
    input logic [CYL_W-1:0] a,
    input logic [CYL_W-1:0] b
  );
    cyl_dist = (a > b) ? a - b : b - a;
  endfunction

  // Busy cycles; never below one so every seek ends with a done pulse
  function automatic logic [CNT_W-1:0] busy_len(
    input logic [WAIT_W-1:0] w,
    input logic [CYL_W-1:0]  d
  );
    logic [CNT_W-1:0] p;
    p = CNT_W'(w) * CNT_W'(d);
    busy_len = (p == '0) ? CNT_W'(1) : p;
  endfunction

  logic [CYL_W-1:0] ofs;
  logic             outward;
  logic [CYL_W:0]   lim;
  logic             unused_addr_bits;

  assign ofs      = addr[ADDR_W-1:OFS_LSB];
  assign outward  = addr[DIR_BIT];
  assign lim      = big ? BIG_LIM : STD_LIM;
  assign unused_addr_bits = ^{addr[OFS_LSB-1:HEAD_BIT+1], addr[HEAD_BIT-1:DIR_BIT+1], addr[DIR_BIT-1:0]};

  always_comb begin
    nxt_pos.cyl  = step_cyl(cur_pos.cyl, ofs, outward, lim);
    nxt_pos.head = addr[HEAD_BIT];
    load_cnt     = busy_len(wait_val, cyl_dist(nxt_pos.cyl, cur_pos.cyl));
  end
endmodule

// File: rtl/seek_unit.sv
module seek_unit
  import seek_pkg::*;
#(
  parameter int CNT_W = 33
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             accept,
  input  drive_pos_t       nxt_pos,
  input  logic [CNT_W-1:0] load_cnt,
  output drive_pos_t       pos,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic             last_tick;

  assign busy      = (cnt != '0);
  assign last_tick = (cnt == CNT_W'(1));

  // Position survives the controller reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      pos <= '0;
    else if (accept) pos <= nxt_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_tick;
      if (accept)    cnt <= load_cnt;
      else if (busy) cnt <= cnt - 1'b1;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (load_cnt != '0)); // R7
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !accept |=> $stable(pos)); // R8
endmodule

// File: rtl/seek_tracker.sv
module seek_tracker
  import seek_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int WAIT_W     = 24,
  parameter int WAIT_RESET = 10,
  parameter int STD_CYLS   = 256,
  parameter int BIG_CYLS   = 512,
  parameter int IDX_W      = $clog2(NUM_DRIVES)
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [WAIT_W-1:0]        cfg_wait,
  input  logic                     seek_start,
  input  logic [IDX_W-1:0]         drive_sel,
  input  logic [ADDR_W-1:0]        disk_addr,
  input  logic [NUM_DRIVES-1:0]    big_drive,
  output logic [NUM_DRIVES-1:0]    drive_busy,
  output logic [NUM_DRIVES-1:0]    seek_done,
  output logic [NUM_DRIVES*ADDR_W-1:0] pos_word
);
  localparam int CNT_W = WAIT_W + CYL_W;
  localparam logic [CYL_W:0] STD_LIM = (CYL_W+1)'(STD_CYLS);

  logic [WAIT_W-1:0] wait_q;
  drive_pos_t        pos_arr [NUM_DRIVES];
  drive_pos_t        cur_pos;
  drive_pos_t        nxt_pos;
  logic [CNT_W-1:0]  load_cnt;
  logic              sel_busy;
  logic              sel_big;
  logic              accept_any;
  logic [NUM_DRIVES-1:0] accept_vec;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      wait_q <= WAIT_W'(WAIT_RESET);
    else if (cfg_wr) wait_q <= cfg_wait;
  end

  assign cur_pos    = pos_arr[drive_sel];
  assign sel_busy   = drive_busy[drive_sel];
  assign sel_big    = big_drive[drive_sel];
  assign accept_any = seek_start && rst_n && !sel_busy;

  seek_calc #(
    .WAIT_W(WAIT_W), .STD_CYLS(STD_CYLS), .BIG_CYLS(BIG_CYLS), .CNT_W(CNT_W)
  ) calc_i (
    .cur_pos (cur_pos),
    .addr    (disk_addr),
    .big     (sel_big),
    .wait_val(wait_q),
    .nxt_pos (nxt_pos),
    .load_cnt(load_cnt)
  );

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    assign accept_vec[d] = accept_any && (drive_sel == IDX_W'(d));

    seek_unit #(.CNT_W(CNT_W)) unit_i (
      .clk     (clk),
      .por_n   (por_n),
      .rst_n   (rst_n),
      .accept  (accept_vec[d]),
      .nxt_pos (nxt_pos),
      .load_cnt(load_cnt),
      .pos     (pos_arr[d]),
      .busy    (drive_busy[d]),
      .done    (seek_done[d])
    );

    assign pos_word[d*ADDR_W +: ADDR_W] =
      {pos_arr[d].cyl, pos_arr[d].head, {POS_HEAD_BIT{1'b0}}};
  end

  AST_STD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_any && !sel_big) |-> ({1'b0, nxt_pos.cyl} < STD_LIM)); // R4
  AST_INWARD_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_any && !disk_addr[DIR_BIT]) |-> (nxt_pos.cyl <= cur_pos.cyl)); // R3
  AST_OUTWARD_NOT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_any && disk_addr[DIR_BIT]) |-> (nxt_pos.cyl >= cur_pos.cyl)); // R2
  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept_vec)); // R11
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |-> (drive_busy == '0 && seek_done == '0)); // R8
endmodule

// File: tb/seek_tracker_tb_top.sv
`timescale 1ns/1ps
module seek_tracker_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [23:0] cfg_wait = '0;
  logic        seek_start = 1'b0;
  logic [1:0]  drive_sel = '0;
  logic [15:0] disk_addr = '0;
  logic [3:0]  big_drive = 4'b0100;
  logic [3:0]  drive_busy, seek_done;
  logic [63:0] pos_word;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  seek_tracker dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wait(cfg_wait),
    .seek_start(seek_start), .drive_sel(drive_sel), .disk_addr(disk_addr),
    .big_drive(big_drive), .drive_busy(drive_busy), .seek_done(seek_done),
    .pos_word(pos_word)
  );

  // Behavioural reference model
  int     m_cyl [4];
  int     m_head[4];
  longint m_rem [4];
  bit     m_done[4];
  longint m_wait;

  always @(posedge clk) begin
    longint w_old;
    if (!por_n) begin
      m_wait = 10;
      for (int d = 0; d < 4; d++) begin
        m_cyl[d] = 0; m_head[d] = 0; m_rem[d] = 0; m_done[d] = 0;
      end
    end else begin
      w_old = m_wait;
      if (cfg_wr) m_wait = cfg_wait;
      for (int d = 0; d < 4; d++) begin
        if (!rst_n) begin
          m_rem[d] = 0; m_done[d] = 0;
        end else begin
          bit was_busy;
          was_busy  = (m_rem[d] != 0);
          m_done[d] = (m_rem[d] == 1);
          if (m_rem[d] > 0) m_rem[d]--;
          if (seek_start && drive_sel == d && !was_busy) begin
            int tgt, top, moved;
            top = big_drive[d] ? 511 : 255;
            if (disk_addr[2]) tgt = m_cyl[d] + int'(disk_addr[15:7]);
            else              tgt = m_cyl[d] - int'(disk_addr[15:7]);
            if (tgt > top) tgt = top;
            if (tgt < 0)   tgt = 0;
            moved = (tgt > m_cyl[d]) ? tgt - m_cyl[d] : m_cyl[d] - tgt;
            m_rem[d]  = w_old * moved;
            if (m_rem[d] == 0) m_rem[d] = 1;
            m_cyl[d]  = tgt;
            m_head[d] = disk_addr[4];
          end
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (por_n) begin
      for (int d = 0; d < 4; d++) begin
        logic [15:0] ew;
        ew = 16'((m_cyl[d] << 7) | (m_head[d] << 6));
        checks += 3;
        if (drive_busy[d] !== (m_rem[d] != 0)) begin
          errors++;
          $display("FAIL R6 busy drive %0d cycle %0d: got %b exp %b", d, cyc, drive_busy[d], m_rem[d] != 0);
        end
        if (seek_done[d] !== m_done[d]) begin
          errors++;
          $display("FAIL R6 done drive %0d cycle %0d: got %b exp %b", d, cyc, seek_done[d], m_done[d]);
        end
        if (pos_word[d*16 +: 16] !== ew) begin
          errors++;
          $display("FAIL R5 pos drive %0d cycle %0d: got %h exp %h", d, cyc, pos_word[d*16 +: 16], ew);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mk_addr(input int ofs, input bit outward, input bit head);
    return 16'((ofs << 7) | (int'(head) << 4) | (int'(outward) << 2));
  endfunction

  task automatic seek(input int d, input logic [15:0] a);
    @(negedge clk);
    seek_start = 1'b1; drive_sel = 2'(d); disk_addr = a;
    @(negedge clk);
    seek_start = 1'b0;
  endtask

  task automatic set_wait(input int w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wait = 24'(w);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Called at the negedge just after the start: counts busy cycles, checks done
  task automatic run_len(input int d, input string tag, input longint exp_len);
    longint n = 0;
    while (drive_busy[d] && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(tag, n, exp_len);
    check("R6 done pulse after busy", seek_done[d], 1);
    @(negedge clk);
    check("R6 done lasts one cycle", seek_done[d], 0);
  endtask

  function automatic int cyl_of(input int d);
    return int'(pos_word[d*16+7 +: 9]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset busy clear", drive_busy, 0);
    check("R5 reset position zero", pos_word, 0);

    // R10 default wait 10; R1 fields; outward by 5 to head 1
    seek(0, mk_addr(5, 1, 1) | 16'h002B);
    run_len(0, "R10 default wait 10 x 5 cylinders", 50);
    check("R1 offset field", cyl_of(0), 5);
    check("R5 head bit 6", pos_word[6], 1);
    check("R5 low bits zero", pos_word[5:0], 0);

    set_wait(2);
    seek(0, mk_addr(3, 0, 0));
    run_len(0, "R10 new wait 2 x 3", 6);
    check("R3 inward subtract", cyl_of(0), 2);
    seek(0, mk_addr(10, 0, 0));
    run_len(0, "R3 clamp distance", 4);
    check("R3 clamp to 0", cyl_of(0), 0);

    seek(0, mk_addr(0, 1, 1));
    run_len(0, "R7 zero distance one cycle", 1);
    seek(0, mk_addr(3, 0, 0));
    run_len(0, "R7 inward at 0 one cycle", 1);

    seek(1, mk_addr(300, 1, 0));
    run_len(1, "R2 clamp distance std", 510);
    check("R2 R4 clamp 255", cyl_of(1), 255);

    seek(2, mk_addr(511, 1, 1));
    run_len(2, "R4 large drive distance", 1022);
    check("R4 clamp 511", cyl_of(2), 511);
    seek(2, mk_addr(1, 0, 0));
    run_len(2, "R4 step in from top", 2);
    check("R4 510", cyl_of(2), 510);

    // R9: start on a busy drive is ignored
    set_wait(3);
    seek(3, mk_addr(4, 1, 0));
    seek(3, mk_addr(100, 1, 1));
    check("R9 position kept", cyl_of(3), 4);
    check("R9 head kept", pos_word[3*16+6], 0);
    repeat (12) @(negedge clk);
    check("R9 timing kept", drive_busy[3], 0);

    // R11: overlapping seeks on two drives
    seek(3, mk_addr(4, 1, 0));
    seek(1, mk_addr(5, 0, 1));
    check("R11 both busy", drive_busy & 4'b1010, 4'b1010);
    check("R11 drive 0 untouched", cyl_of(0), 0);
    repeat (20) @(negedge clk);
    check("R11 cyl d3", cyl_of(3), 8);
    check("R11 cyl d1", cyl_of(1), 250);

    // R8: controller reset mid-seek keeps positions
    seek(2, mk_addr(50, 0, 1));
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 busy cancelled", drive_busy, 0);
    check("R8 position kept", cyl_of(2), 460);
    seek(0, mk_addr(9, 1, 0));
    check("R8 start ignored in reset", cyl_of(0), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 no done after reset", seek_done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule